// File: doc/BRIEF.md
# Pulse-to-Level Interrupt Merger

This block joins two peripheral interrupt sources onto one shared, active-high host interrupt line. The first source is a parallel-port controller. It signals with brief strobes that can be shorter than the host needs to notice them. The block captures each strobe in a held flag and keeps the request raised until software talks to that controller. Any bus access to the controller clears the flag. The chip select is active for every register of the controller, the unused ones included, and for reads as well as writes. The second source is a UART whose interrupt is already a level, so it is passed through combinationally with no storage.

The strobe input may arrive from another clock domain. It passes through a synchronizer chain and is then reduced to its rising edge, so a long strobe counts as one event. On a board that is configured by the host at start-up (`slot_mode` high), the merged request is held off until a one-cycle `cfg_done` pulse has been seen. Without that mode the request is never held off. A held strobe survives the gated period and shows up once the gate opens. No register reports which source raised the request. Software asks the two controllers.

Top module: `strobe_irq_merge`

## Requirements
- R1: While `rst_n` is low and after its release, `host_irq` is low, the held strobe flag is clear and the configuration flag is clear.
- R2: With the gate open, `host_irq` follows `uart_irq` in the same cycle, with no clock edge in between.
- R3: A rising edge on `pp_strobe` that is driven low-to-high between two clock edges raises `host_irq` after the third rising clock edge that follows. This comes from two synchronizer stages and one flag register. After the second edge, `host_irq` is still low.
- R4: Once set, the held flag keeps `host_irq` high after `pp_strobe` has returned low, for as long as `pp_cs` stays low.
- R5: A clock edge at which `pp_cs` is high clears the held flag. The chip select covers every controller register, reads and writes alike.
- R6: If a strobe edge and a `pp_cs` access fall on the same clock edge, the flag is set and is not cleared.
- R7: With `slot_mode` high, `host_irq` stays low for both sources until a clock edge has sampled `cfg_done` high. After that edge, the configuration flag stays set until reset.
- R8: With `slot_mode` low, `host_irq` is never gated and `cfg_done` has no effect.
- R9: `uart_irq` is not latched. When it falls, `host_irq` falls with it, with no controller access.
- R10: A strobe held high for many cycles sets the flag once. After an access clears the flag, the flag stays clear while the strobe remains high.
- R11: A strobe that arrives while the output is gated is kept in the flag. It drives `host_irq` high as soon as the configuration flag sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_mode | input | 1 | High when the board is configured by the host, which enables output gating |
| cfg_done | input | 1 | One-cycle pulse: host configuration has finished |
| pp_strobe | input | 1 | Asynchronous interrupt strobe from the parallel-port controller |
| uart_irq | input | 1 | Level interrupt from the UART |
| pp_cs | input | 1 | Parallel-port controller chip select, one cycle per bus access |
| host_irq | output | 1 | Merged, active-high host interrupt request |

## Verification
The held flag is driven with a one-cycle strobe, a strobe that stays high for many cycles, and a strobe whose edge meets an access on the same clock edge. These three cases separate correct edge detection and set-over-clear priority from a level-sensitive or clear-first flag. The UART input is raised and dropped on its own to show that it passes through in the same cycle and is never stored. Gating is tried in both board modes, with the UART level and with a strobe that arrives before configuration. This separates a gate on the output from one that throws away events or leaves the gate open.

// File: rtl/strobe_irq_pkg.sv
package strobe_irq_pkg;

  // Number of flops between the asynchronous strobe and the edge detector.
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // The two request sources as seen by the output gate.
  typedef struct packed {
    logic held;   // captured controller strobe
    logic level;  // UART level request
  } irq_src_t;

endpackage

// File: rtl/strobe_irq_sync.sv
module strobe_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];

endmodule

// File: rtl/strobe_irq_edge.sv
module strobe_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign rise = level_in & ~prev_q;

endmodule

// File: rtl/strobe_irq_hold.sv
module strobe_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic held_o
);

  // Set has priority so that an event meeting an access is not lost.
  always_ff @(posedge clk) begin
    if (!rst_n)     held_o <= 1'b0;
    else if (set_i) held_o <= 1'b1;
    else if (clr_i) held_o <= 1'b0;
  end

endmodule

// File: rtl/strobe_irq_gate.sv
module strobe_irq_gate
  import strobe_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     slot_mode,
  input  logic     cfg_done,
  input  irq_src_t src,
  output logic     cfg_q,
  output logic     irq_o
);

  logic enable;

  // Sticky: once configured, the board remains configured until reset.
  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= 1'b0;
    else if (cfg_done) cfg_q <= 1'b1;
  end

  assign enable = ~slot_mode | cfg_q;
  assign irq_o  = enable & (src.held | src.level);

endmodule

// File: rtl/strobe_irq_merge.sv
module strobe_irq_merge
  import strobe_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_mode,
  input  logic cfg_done,
  input  logic pp_strobe,
  input  logic uart_irq,
  input  logic pp_cs,
  output logic host_irq
);

  logic     strobe_sync;
  logic     pulse_rise;
  logic     held_q;
  logic     cfg_q;
  irq_src_t sources;

  strobe_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pp_strobe),
    .q_sync  (strobe_sync)
  );

  strobe_irq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (strobe_sync),
    .rise     (pulse_rise)
  );

  strobe_irq_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (pulse_rise),
    .clr_i  (pp_cs),
    .held_o (held_q)
  );

  assign sources.held  = held_q;
  assign sources.level = uart_irq;

  strobe_irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_mode (slot_mode),
    .cfg_done  (cfg_done),
    .src       (sources),
    .cfg_q     (cfg_q),
    .irq_o     (host_irq)
  );

endmodule

// File: rtl/strobe_irq_merge_chk.sv
module strobe_irq_merge_chk (
  input logic clk,
  input logic rst_n,
  input logic slot_mode,
  input logic uart_irq,
  input logic pp_cs,
  input logic host_irq,
  input logic pulse_rise,
  input logic held_q,
  input logic cfg_q
);

  a_r2_uart_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_irq && (!slot_mode || cfg_q)) |-> host_irq);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !pp_cs) |=> held_q);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_cs && !pulse_rise) |=> !held_q);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_rise |=> held_q);

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_mode && !cfg_q) |-> !host_irq);

  a_r7_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |=> cfg_q);

  a_r11_held_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && (!slot_mode || cfg_q)) |-> host_irq);

endmodule

bind strobe_irq_merge strobe_irq_merge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_mode  (slot_mode),
  .uart_irq   (uart_irq),
  .pp_cs      (pp_cs),
  .host_irq   (host_irq),
  .pulse_rise (pulse_rise),
  .held_q     (held_q),
  .cfg_q      (cfg_q)
);

// File: tb/strobe_irq_merge_tb.sv
`timescale 1ns/1ps
module strobe_irq_merge_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_mode = 1'b0;
  logic cfg_done = 1'b0;
  logic pp_strobe = 1'b0;
  logic uart_irq = 1'b0;
  logic pp_cs = 1'b0;
  logic host_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strobe_irq_merge dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_mode (slot_mode),
    .cfg_done  (cfg_done),
    .pp_strobe (pp_strobe),
    .uart_irq  (uart_irq),
    .pp_cs     (pp_cs),
    .host_irq  (host_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: host_irq=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    slot_mode = mode;
    pp_strobe = 1'b0; uart_irq = 1'b0; pp_cs = 1'b0; cfg_done = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", host_irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", host_irq, 1'b0);
  endtask

  // One-cycle strobe; returns at the falling edge after the first sampling edge.
  task automatic strobe_once();
    @(negedge clk) pp_strobe = 1'b1;
    @(negedge clk) pp_strobe = 1'b0;
  endtask

  task automatic access();
    @(negedge clk) pp_cs = 1'b1;
    @(negedge clk) pp_cs = 1'b0;
  endtask

  task automatic t_uart_pass();
    @(negedge clk) uart_irq = 1'b1;
    #1 check("R2 uart rise same cycle", host_irq, 1'b1);
    @(negedge clk) uart_irq = 1'b0;
    #1 check("R9 uart fall same cycle", host_irq, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 uart not latched", host_irq, 1'b0);
  endtask

  task automatic t_strobe_latency_hold_clear();
    strobe_once();
    @(negedge clk);
    check("R3 low after second edge", host_irq, 1'b0);
    @(negedge clk);
    check("R3 high after third edge", host_irq, 1'b1);
    repeat (10) @(negedge clk);
    check("R4 held without access", host_irq, 1'b1);
    access();
    check("R5 cleared by access", host_irq, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 stays clear", host_irq, 1'b0);
  endtask

  task automatic t_set_wins();
    strobe_once();
    @(negedge clk) pp_cs = 1'b1;   // edge k+2 carries both set and clear
    @(negedge clk) pp_cs = 1'b0;
    check("R6 set wins over access", host_irq, 1'b1);
    access();
    check("R6 later access clears", host_irq, 1'b0);
  endtask

  task automatic t_long_strobe();
    @(negedge clk) pp_strobe = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 long strobe sets", host_irq, 1'b1);
    access();
    repeat (6) @(negedge clk);
    check("R10 no re-set while strobe high", host_irq, 1'b0);
    pp_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 still clear after strobe low", host_irq, 1'b0);
  endtask

  task automatic t_addon_cfg_ignored();
    @(negedge clk) cfg_done = 1'b1;
    @(negedge clk) cfg_done = 1'b0;
    #1 check("R8 cfg_done no effect", host_irq, 1'b0);
    uart_irq = 1'b1;
    #1 check("R8 ungated in add-on mode", host_irq, 1'b1);
    @(negedge clk) uart_irq = 1'b0;
  endtask

  task automatic t_gating();
    @(negedge clk) uart_irq = 1'b1;
    #1 check("R7 uart gated before config", host_irq, 1'b0);
    @(negedge clk) uart_irq = 1'b0;
    strobe_once();
    repeat (4) @(negedge clk);
    check("R7 strobe gated before config", host_irq, 1'b0);
    @(negedge clk) cfg_done = 1'b1;
    #1 check("R7 gate still closed before edge", host_irq, 1'b0);
    @(negedge clk) cfg_done = 1'b0;
    check("R11 held strobe shows after config", host_irq, 1'b1);
    access();
    check("R5 clear in slot mode", host_irq, 1'b0);
    repeat (5) @(negedge clk);
    uart_irq = 1'b1;
    #1 check("R7 config flag sticky", host_irq, 1'b1);
    @(negedge clk) uart_irq = 1'b0;
  endtask

  initial begin
    do_reset(1'b0);
    t_uart_pass();
    t_strobe_latency_hold_clear();
    t_set_wins();
    t_long_strobe();
    t_addon_cfg_ignored();
    do_reset(1'b1);
    t_gating();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule